// File: doc/BRIEF.md
# Synchronous Half-Duplex Byte Shifter

This block moves bytes over a clocked two-wire link: it drives a shift clock and uses one data line in either direction. A host hands it a byte over a valid/ready input to start a transmission. To start a reception, the host clears the receive-complete flag while receive is enabled. Each transfer is eight bits, least significant first. One bit period lasts a fixed number of system clock cycles.

In every bit period the shift clock is low for the first half and high for the second half. Between transfers it rests high. An outgoing bit appears on the data line well before the rising shift-clock edge and stays a short while after it. An incoming bit is taken from the value on the line just as the clock rises.

Two sticky flags report the end of each transfer. They are cleared only by their strobes. The byte input uses valid/ready with the following rules:
- `wr_ready` is high only while the port is idle.
- A beat is taken in any cycle where `wr_valid` and `wr_ready` are both high.
- While a transfer runs, `wr_ready` is low. A valid offered in that time is simply not taken, and no data is queued.

The data line is split into separate in, out and enable pins, so the pad can be built outside the block.

Top module: `ser_shifter`

## Requirements
- R1: After reset both flags are 0, `sd_oe` is 0, `sclk` is 1 and `wr_ready` is 1.
- R2: `sclk` is 1 while idle. In a transfer, each 12-cycle bit period has `sclk` low for 6 cycles and then high for 6. Counting from cycle 0, the first cycle after the accepting edge, the first low cycle is cycle 4.
- R3: An accepted write sends bit k of `wr_data` on `sd_out` during cycles 12k to 12k+11. This gives 10 cycles before the k-th rising edge and 2 cycles after it. `sd_oe` is 1 for cycles 0 to 95.
- R4: In cycle 96 of a transmission `tx_done` is 1, `sd_oe` is 0, `sclk` is 1 and `wr_ready` is 1.
- R5: A reception leaves `sd_oe` at 0. Bit k is the value of `sd_in` in cycle 12k+9, which is the cycle just before the k-th rising edge. Bits are assembled least significant first.
- R6: In cycle 96 of a reception `rx_done` is 1 and `rx_data` holds the received byte.
- R7: A `rx_done_clr` pulse with `rx_en` at 0 clears `rx_done` and starts no transfer.
- R8: While a transfer runs, `wr_ready` is 0. Write beats and receive starts offered then have no effect on the bits on the line or on the port after the transfer.
- R9: Each flag stays set until its clear strobe. When a clear arrives in the same cycle as a set, the set wins.
- R10: If a write beat and a receive start arrive together at idle, the transmission is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Transmit byte offered |
| wr_ready | output | 1 | Port idle, write beat can be taken |
| wr_data | input | 8 | Byte to transmit |
| tx_done | output | 1 | Transmit-complete flag |
| tx_done_clr | input | 1 | Clear strobe for `tx_done` |
| rx_en | input | 1 | Reception permitted |
| rx_done_clr | input | 1 | Clear strobe for `rx_done`; starts a reception when idle and `rx_en` is 1 |
| rx_done | output | 1 | Receive-complete flag |
| rx_data | output | 8 | Last received byte |
| sd_in | input | 1 | Data line input |
| sd_out | output | 1 | Data line output value |
| sd_oe | output | 1 | Data line output enable |
| sclk | output | 1 | Shift clock |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, a 12-cycle bit period with a 6-cycle low phase, and 2 cycles of hold after each rising edge. These values keep a transfer at 97 cycles, so every one of the 256 byte values can be sent and received.

While receiving, the bench drives the inverse of the wanted bit in every cycle except the single sampling cycle. This pins the capture point to one exact cycle. Each transmitted bit is checked in every cycle of its period, so both the setup window and the hold window are covered. The set-against-clear collision, the ignored mid-transfer beats and the simultaneous start are each placed on an exact cycle of a chosen transfer.

// File: rtl/ssh_pkg.sv
package ssh_pkg;
  typedef enum logic [1:0] {
    MD_IDLE = 2'd0,
    MD_TX   = 2'd1,
    MD_RX   = 2'd2
  } mode_t;
endpackage

// File: rtl/ssh_timer.sv
module ssh_timer #(
  parameter int WIDTH = 8,
  parameter int DIV   = 12,
  parameter int LOW   = 6,
  parameter int HOLD  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic sclk,
  output logic shift_stb,
  output logic samp_stb,
  output logic last_stb
);
  localparam int CW   = $clog2(DIV);
  localparam int BW   = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam int CHG  = (LOW + HOLD) % DIV;       // cycle where next bit appears
  localparam int ENDC = (CHG + DIV - 1) % DIV;    // last cycle of a bit slot
  localparam int SAMP = LOW - 1;                  // cycle before the rise

  logic [CW-1:0] cnt_q;
  logic [BW-1:0] bit_q;
  logic          slot_end;
  logic          on_last;

  assign slot_end = run && (cnt_q == CW'(ENDC));
  assign on_last  = (bit_q == BW'(WIDTH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CW'(CHG);
      bit_q <= '0;
    end else if (start) begin
      cnt_q <= CW'(CHG);
      bit_q <= '0;
    end else if (run) begin
      cnt_q <= (cnt_q == CW'(DIV - 1)) ? '0 : cnt_q + 1'b1;
      if (slot_end && !on_last) bit_q <= bit_q + 1'b1;
    end
  end

  assign sclk      = !(run && (cnt_q < CW'(LOW)));
  assign shift_stb = slot_end && !on_last;
  assign last_stb  = slot_end && on_last;
  assign samp_stb  = run && (cnt_q == CW'(SAMP));
endmodule

// File: rtl/ssh_shreg.sv
module ssh_shreg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_data,
  input  logic             shift,
  input  logic             capture,
  input  logic             din,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (load)    q <= load_data;
    else if (shift)   q <= {1'b0, q[WIDTH-1:1]};
    else if (capture) q <= {din, q[WIDTH-1:1]};
  end
endmodule

// File: rtl/ssh_ctl.sv
module ssh_ctl
  import ssh_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic             rx_en,
  input  logic             tx_clr,
  input  logic             rx_clr,
  input  logic             last_stb,
  input  logic [WIDTH-1:0] sh_q,
  output logic             tx_go,
  output logic             rx_go,
  output logic             is_tx,
  output logic             is_rx,
  output logic             idle,
  output logic             tx_flag,
  output logic             rx_flag,
  output logic [WIDTH-1:0] rx_buf
);
  mode_t mode_q;

  assign idle  = (mode_q == MD_IDLE);
  assign is_tx = (mode_q == MD_TX);
  assign is_rx = (mode_q == MD_RX);
  assign tx_go = idle && wr_valid;
  assign rx_go = idle && !wr_valid && rx_clr && rx_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode_q <= MD_IDLE;
    else if (tx_go)    mode_q <= MD_TX;
    else if (rx_go)    mode_q <= MD_RX;
    else if (last_stb) mode_q <= MD_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_flag <= 1'b0;
      rx_flag <= 1'b0;
      rx_buf  <= '0;
    end else begin
      if (last_stb && is_tx) tx_flag <= 1'b1;
      else if (tx_clr)       tx_flag <= 1'b0;
      if (last_stb && is_rx) begin
        rx_flag <= 1'b1;
        rx_buf  <= sh_q;
      end else if (rx_clr) begin
        rx_flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter #(
  parameter int WIDTH = 8,
  parameter int DIV   = 12,
  parameter int LOW   = 6,
  parameter int HOLD  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [WIDTH-1:0] wr_data,
  output logic             tx_done,
  input  logic             tx_done_clr,
  input  logic             rx_en,
  input  logic             rx_done_clr,
  output logic             rx_done,
  output logic [WIDTH-1:0] rx_data,
  input  logic             sd_in,
  output logic             sd_out,
  output logic             sd_oe,
  output logic             sclk
);
  logic tx_go, rx_go, is_tx, is_rx, idle;
  logic shift_stb, samp_stb, last_stb;
  logic [WIDTH-1:0] sh_q;

  ssh_timer #(.WIDTH(WIDTH), .DIV(DIV), .LOW(LOW), .HOLD(HOLD)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(tx_go || rx_go), .run(!idle),
    .sclk(sclk), .shift_stb(shift_stb), .samp_stb(samp_stb),
    .last_stb(last_stb)
  );

  ssh_shreg #(.WIDTH(WIDTH)) u_sh (
    .clk(clk), .rst_n(rst_n), .load(tx_go), .load_data(wr_data),
    .shift(is_tx && shift_stb), .capture(is_rx && samp_stb),
    .din(sd_in), .q(sh_q)
  );

  ssh_ctl #(.WIDTH(WIDTH)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .rx_en(rx_en),
    .tx_clr(tx_done_clr), .rx_clr(rx_done_clr), .last_stb(last_stb),
    .sh_q(sh_q), .tx_go(tx_go), .rx_go(rx_go), .is_tx(is_tx),
    .is_rx(is_rx), .idle(idle), .tx_flag(tx_done), .rx_flag(rx_done),
    .rx_buf(rx_data)
  );

  assign wr_ready = idle;
  assign sd_oe    = is_tx;
  assign sd_out   = is_tx ? sh_q[0] : 1'b1;
endmodule

// File: rtl/ssh_chk.sv
module ssh_chk #(
  parameter int LOW = 6
) (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic sd_oe,
  input logic sd_out,
  input logic wr_ready,
  input logic tx_done,
  input logic tx_done_clr,
  input logic rx_done,
  input logic rx_done_clr
);
  logic [7:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    low_run <= '0;
    else if (!sclk) low_run <= low_run + 1'b1;
    else           low_run <= '0;
  end

  // R2: the port rests with the shift clock high
  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> sclk);

  // R2: every low phase lasts exactly LOW cycles
  a_r2_low_run: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && !$past(sclk)) |-> (low_run == 8'(LOW)));

  // R3: the line is driven only while busy
  a_r3_oe_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sd_oe |-> !wr_ready);

  // R3: outgoing data is steady while the shift clock is low
  a_r3_steady_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_oe && $past(sd_oe) && !sclk) |-> $stable(sd_out));

  // R4: the done flag rises as the port returns to idle
  a_r4_flag_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> (wr_ready && !sd_oe));

  // R9: flags hold until cleared
  a_r9_tx_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !tx_done_clr) |=> tx_done);

  a_r9_rx_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rx_done_clr) |=> rx_done);
endmodule

bind ser_shifter ssh_chk #(.LOW(LOW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .sd_oe(sd_oe), .sd_out(sd_out),
  .wr_ready(wr_ready), .tx_done(tx_done), .tx_done_clr(tx_done_clr),
  .rx_done(rx_done), .rx_done_clr(rx_done_clr)
);

// File: tb/sim_ser_shifter.sv
module sim_ser_shifter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [7:0] wr_data = '0;
  logic tx_done;
  logic tx_done_clr = 1'b0;
  logic rx_en = 1'b0;
  logic rx_done_clr = 1'b0;
  logic rx_done;
  logic [7:0] rx_data;
  logic sd_in = 1'b1;
  logic sd_out, sd_oe, sclk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ser_shifter u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .tx_done(tx_done), .tx_done_clr(tx_done_clr),
    .rx_en(rx_en), .rx_done_clr(rx_done_clr), .rx_done(rx_done),
    .rx_data(rx_data), .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe),
    .sclk(sclk)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_sclk(input int c);
    int ph = (8 + c) % 12;
    return (ph < 6) ? 0 : 1;
  endfunction

  task automatic idle_checks(input string tag);
    check({tag, " sclk idle"}, sclk, 1);
    check({tag, " oe idle"}, sd_oe, 0);
    check({tag, " ready idle"}, wr_ready, 1);
  endtask

  // called at a negedge; returns at the negedge of cycle 96
  task automatic run_tx(input logic [7:0] b, input bit poke,
                        input bit clr95, input bit with_rx, input int prev_flag);
    wr_valid = 1'b1;
    wr_data = b;
    if (with_rx) begin rx_en = 1'b1; rx_done_clr = 1'b1; end
    @(negedge clk);
    wr_valid = 1'b0;
    rx_done_clr = 1'b0;
    check("R9 tx flag kept across start", tx_done, prev_flag);
    for (int c = 0; c < 96; c++) begin
      check(with_rx ? "R10 tx wins oe" : "R3 oe", sd_oe, 1);
      check("R3 bit value", sd_out, int'(b[c / 12]));
      check("R2 sclk shape", sclk, exp_sclk(c));
      check("R8 ready low", wr_ready, 0);
      if (poke && c == 30) begin
        wr_valid = 1'b1; wr_data = ~b; rx_en = 1'b1; rx_done_clr = 1'b1;
      end
      if (poke && c == 31) begin
        wr_valid = 1'b0; rx_done_clr = 1'b0;
      end
      if (clr95 && c == 95) tx_done_clr = 1'b1;
      @(negedge clk);
    end
    tx_done_clr = 1'b0;
    check(clr95 ? "R9 set beats clear" : "R4 tx flag", tx_done, 1);
    idle_checks("R4");
  endtask

  task automatic run_rx(input logic [7:0] b);
    rx_en = 1'b1;
    rx_done_clr = 1'b1;
    @(negedge clk);
    rx_done_clr = 1'b0;
    check("R9 rx flag cleared", rx_done, 0);
    for (int c = 0; c < 96; c++) begin
      sd_in = (c % 12 == 9) ? b[c / 12] : ~b[c / 12];
      check("R5 oe off", sd_oe, 0);
      check("R2 sclk shape rx", sclk, exp_sclk(c));
      check("R8 ready low rx", wr_ready, 0);
      @(negedge clk);
    end
    check("R6 rx flag", rx_done, 1);
    check("R5 rx byte", rx_data, int'(b));
    idle_checks("R6");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 tx flag in reset", tx_done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 tx flag", tx_done, 0);
    check("R1 rx flag", rx_done, 0);
    check("R1 oe", sd_oe, 0);
    check("R1 sclk", sclk, 1);
    check("R1 ready", wr_ready, 1);

    // transmit sweep over all byte values
    for (int b = 0; b < 256; b++) begin
      run_tx(8'(b), b == 5, b == 9, 1'b0, (b > 0) ? 1 : 0);
      if (b == 5) begin
        // R8: the mid-transfer beats left nothing behind
        for (int k = 0; k < 3; k++) begin
          idle_checks("R8 after poke");
          @(negedge clk);
        end
      end
    end

    // R9: explicit clear
    tx_done_clr = 1'b1;
    @(negedge clk);
    tx_done_clr = 1'b0;
    check("R9 tx cleared", tx_done, 0);

    // receive sweep over all byte values
    for (int b = 0; b < 256; b++) run_rx(8'(b));

    // R7: clear without enable
    rx_en = 1'b0;
    rx_done_clr = 1'b1;
    @(negedge clk);
    rx_done_clr = 1'b0;
    check("R7 flag cleared", rx_done, 0);
    for (int k = 0; k < 20; k++) begin
      idle_checks("R7 no start");
      @(negedge clk);
    end

    // R10: simultaneous write and receive start
    run_tx(8'hA5, 1'b0, 1'b0, 1'b1, 0);
    check("R10 rx flag only cleared", rx_done, 0);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule